// File: doc/BRIEF.md
# Stereo Zero-Cross Detector

This block watches the stream of audio samples that an audio serial port moves between its shift registers and its sample buffers. For each of the two channels it raises a sticky flag when the waveform crosses zero. A crossing is either a change of sign against the channel's previous sample or a sample whose data bits are all zero. Software or a gain stage reads the flag to time volume changes so that they cause no audible click.

Each sample arrives with a one-cycle valid strobe, a channel select and a data word. A 2-bit width select sets how many data bits count, and so sets where the sign bit sits. Each channel has its own detection enable, write-1-to-clear strobe and interrupt enable. Each channel drives its own flag and interrupt outputs.

Top module: `zc_detector`

## Requirements
- R1: A channel's flag can set only in a cycle where that channel's detection enable is 1. While the enable is 0 the flag reads 0 from the next clock edge on.
- R2: A valid sample sets its channel's flag at the next edge when its sign bit differs from the stored sign of that channel's previous sample. The sign bit is bit 8*(W+1)-1, where W is the width select: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32.
- R3: A valid sample whose low 8*(W+1) bits are all zero sets its channel's flag. Bits above the selected width are ignored for both the zero test and the sign.
- R4: A set flag stays 1 until a 1 is applied on that channel's clear input. The flag reads 0 after that edge. Clearing the channel's enable also clears it.
- R5: A channel's interrupt output equals its flag AND its interrupt enable, in the same cycle and with no register between them.
- R6: Each channel's stored sign resets to 0. It takes the sign of every valid sample of that channel, including samples taken while detection is disabled, so turning detection on raises no false event.
- R7: When a clear and a crossing event for the same channel fall in the same cycle, the flag is 1 after the edge.
- R8: Channel select 0 addresses the left channel (index 0 of every per-channel vector) and 1 addresses the right channel (index 1). A sample affects only its own channel.
- R9: After reset both flags and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_right | input | 1 | Channel of the sample: 0 left, 1 right |
| smp_data | input | 32 | Sample data, right-aligned |
| word_sel | input | 2 | Data width: 0=8, 1=16, 2=24, 3=32 bits |
| det_en | input | 2 | Detection enable per channel |
| flag_clr | input | 2 | Write-1-to-clear strobe per channel |
| irq_en | input | 2 | Interrupt enable per channel |
| zc_flag | output | 2 | Sticky zero-cross flag per channel |
| zc_irq | output | 2 | Interrupt per channel |

## Verification
A flag responds to a sample, a clear or a dropped enable at the first rising edge after that input is presented. An interrupt follows its flag and its enable in the same cycle. The bench therefore drives every input on the falling edge. It updates its reference model on the rising edge that captures those inputs, and compares flags and interrupts one time unit after that edge, while the inputs are still held.

// File: rtl/zc_detector.sv
module zc_detector #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                smp_right,
  input  logic [4*LANE_W-1:0] smp_data,
  input  logic [1:0]          word_sel,
  input  logic [1:0]          det_en,
  input  logic [1:0]          flag_clr,
  input  logic [1:0]          irq_en,
  output logic [1:0]          zc_flag,
  output logic [1:0]          zc_irq
);
  localparam int DATA_W = 4 * LANE_W;

  logic              sign_now;
  logic [DATA_W-1:0] mask;
  logic              all_zero;
  logic [1:0]        prev_sign;

  always_comb begin
    case (word_sel)
      2'd0:    sign_now = smp_data[LANE_W-1];
      2'd1:    sign_now = smp_data[2*LANE_W-1];
      2'd2:    sign_now = smp_data[3*LANE_W-1];
      default: sign_now = smp_data[DATA_W-1];
    endcase
  end

  assign mask     = {DATA_W{1'b1}} >> (LANE_W * (3 - int'(word_sel)));
  assign all_zero = ~|(smp_data & mask);
  assign zc_irq   = zc_flag & irq_en;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic hit, evt;
    assign hit = smp_valid && (smp_right == 1'(c));
    assign evt = hit && det_en[c] && (all_zero || (sign_now != prev_sign[c]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_sign[c] <= 1'b0;
        zc_flag[c]   <= 1'b0;
      end else begin
        if (hit) prev_sign[c] <= sign_now;
        if (!det_en[c])      zc_flag[c] <= 1'b0;
        else if (evt)        zc_flag[c] <= 1'b1;
        else if (flag_clr[c]) zc_flag[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zc_detector_chk.sv
module zc_detector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic        smp_right,
  input logic [31:0] smp_data,
  input logic [1:0]  det_en,
  input logic [1:0]  flag_clr,
  input logic [1:0]  irq_en,
  input logic [1:0]  zc_flag,
  input logic [1:0]  zc_irq
);
  AST_OFF_L: assert property (@(posedge clk) disable iff (!rst_n) !det_en[0] |=> !zc_flag[0]); // R1
  AST_OFF_R: assert property (@(posedge clk) disable iff (!rst_n) !det_en[1] |=> !zc_flag[1]); // R1
  AST_ZERO_L: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_right && det_en[0] && smp_data == '0) |=> zc_flag[0]); // R3
  AST_STICKY_L: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_flag[0] && det_en[0] && !flag_clr[0]) |=> zc_flag[0]); // R4
  AST_STICKY_R: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_flag[1] && det_en[1] && !flag_clr[1]) |=> zc_flag[1]); // R4
  AST_RISE_L: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_flag[0]) |-> $past(smp_valid && !smp_right)); // R8
  AST_RISE_R: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_flag[1]) |-> $past(smp_valid && smp_right)); // R8
  always_comb if (rst_n) AST_IRQ_GATE: assert (zc_irq == (zc_flag & irq_en)); // R5
endmodule

bind zc_detector zc_detector_chk u_chk (.*);

// File: tb/tb_zc_detector.sv
module tb_zc_detector;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_right = 0;
  logic [31:0] smp_data = '0;
  logic [1:0] word_sel = 0, det_en = 0, flag_clr = 0, irq_en = 0;
  logic [1:0] zc_flag, zc_irq;

  int checks = 0, failures = 0;
  logic [1:0] m_sign = 0, m_flag = 0;
  bit done = 0;

  zc_detector dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic sign_of(logic [31:0] d, logic [1:0] w);
    return d[8*(int'(w)+1)-1];
  endfunction

  function automatic logic zero_of(logic [31:0] d, logic [1:0] w);
    for (int i = 0; i < 8*(int'(w)+1); i++) if (d[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic r, logic [31:0] d, logic [1:0] w,
                     logic [1:0] en, logic [1:0] clr, logic [1:0] ie, string tag);
    @(negedge clk);
    smp_valid = v; smp_right = r; smp_data = d; word_sel = w;
    det_en = en; flag_clr = clr; irq_en = ie;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      logic hit, ev;
      hit = v && (int'(r) == c);
      ev = hit && en[c] && (zero_of(d, w) || sign_of(d, w) != m_sign[c]);
      if (!en[c]) m_flag[c] = 0;
      else if (ev) m_flag[c] = 1;
      else if (clr[c]) m_flag[c] = 0;
      if (hit) m_sign[c] = sign_of(d, w);
    end
    #1;
    check(tag, zc_flag, m_flag, "flag");
    check("R5", zc_irq, m_flag & ie, "irq");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2c01));
    repeat (3) @(posedge clk);
    #1;
    check("R9", zc_flag, 2'b00, "reset flag");
    check("R9", zc_irq, 2'b00, "reset irq");
    @(negedge clk); rst_n = 1;

    // R2 positive nonzero after reset sign 0: no event; then negative 8-bit
    cyc(1, 0, 32'h01, 0, 2'b11, 0, 2'b11, "R6");
    cyc(1, 0, 32'h80, 0, 2'b11, 0, 2'b11, "R2");
    cyc(0, 0, 0, 0, 2'b11, 0, 2'b00, "R4");
    cyc(0, 0, 0, 0, 2'b11, 2'b01, 2'b11, "R4");
    // R3 upper bits ignored at 8-bit width: zero sample
    cyc(1, 0, 32'hFFFF_FF00, 0, 2'b11, 0, 2'b11, "R3");
    cyc(0, 0, 0, 0, 2'b11, 2'b01, 2'b11, "R4");
    // R2 16-bit: bit 7 is data not sign
    cyc(1, 0, 32'h0000_0080, 1, 2'b11, 0, 2'b11, "R2");
    cyc(1, 0, 32'h0000_8001, 1, 2'b11, 0, 2'b11, "R2");
    cyc(0, 0, 0, 0, 2'b11, 2'b01, 2'b11, "R4");
    // R8 right sample leaves left alone
    cyc(1, 1, 32'h8000_0000, 3, 2'b11, 0, 2'b11, "R8");
    cyc(0, 0, 0, 0, 2'b11, 2'b10, 2'b11, "R4");
    // R6 stored sign tracks while disabled
    cyc(1, 1, 32'h0000_0001, 3, 2'b01, 0, 2'b11, "R1");
    cyc(1, 1, 32'h8000_0001, 3, 2'b01, 0, 2'b11, "R1");
    cyc(1, 1, 32'h8000_0002, 3, 2'b11, 0, 2'b11, "R6");
    // R7 set beats clear
    cyc(1, 1, 32'h0000_0002, 3, 2'b11, 2'b10, 2'b11, "R7");
    // R4 disable clears
    cyc(0, 0, 0, 0, 2'b01, 0, 2'b11, "R4");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      d = ($urandom % 8 == 0) ? ($urandom & 32'hFF00_0000) : $urandom;
      cyc($urandom % 2 == 0, 1'($urandom), d, 2'($urandom),
          ($urandom % 8 == 0) ? 2'($urandom) : 2'b11,
          ($urandom % 4 == 0) ? 2'($urandom) : 2'b00,
          2'($urandom), "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule